// File: doc/BRIEF.md
# H-Bridge Gate Control Sequencer

This block is the digital core that sits between a motor-control host and the four power switches of a brushed DC motor full bridge. The host supplies a direction bit, a drive-enable bit (usually chopped as PWM), a decay-style select and a run/sleep bit. Supply and die-temperature monitors report through fault flags, and a current comparator raises a near-zero-current flag. The block turns these into four gate enables: a high-side and a low-side switch for each of the two bridge legs.

Every input passes through a two-flop synchroniser before the block uses it. From the synchronised values the block selects one of four behaviours: driving the motor in one direction or the other, braking both legs low, fast decay against the drive direction, or floating the bridge. When fast decay brings the current near zero, the block latches that and floats the bridge so the current cannot reverse. Each leg has its own sequencer. A switch turns off on the next clock edge, but it turns on only after the leg has been fully off for a crossover interval. The block also holds the bridge off for a settling interval after waking and for as long as any fault is present. Both intervals are counted in clock cycles, derived from a clock-rate parameter.

Top module: `hbridge_gate_seq`

## Requirements
- R1: With run high and enable high, direction 1 gives leg A high and leg B low, and direction 0 gives leg A low and leg B high. The decay select and the zero-current flag have no effect in this case.
- R2: With enable low and the decay select high, both legs are driven low (brake), whatever the direction and zero-current inputs are.
- R3: With enable low and the decay select low (fast decay), the legs are driven opposite to the direction input: direction 1 gives A low and B high, and direction 0 gives A high and B low.
- R4: In fast decay, a synchronised zero-current flag sets a latch that turns all four gates off. The latch stays set after the flag drops. It clears when enable goes high, when the decay select goes high, or when the fast-decay direction changes.
- R5: Run low turns all four gates off within SYNC_STAGES+1 clock edges, whatever the other inputs are.
- R6: The high and low gate enables of the same leg are never on in the same cycle.
- R7: A switch turns on only after its leg has had both gates off for at least DT_CYC = CLK_KHZ*DEAD_NS/1,000,000 cycles. On a reversal of a driven leg, the leg is fully off for exactly DT_CYC+1 cycles.
- R8: While the undervoltage or over-temperature flag is high, all gates are off, and drive resumes once the flag clears. After reset the gates stay off until the undervoltage flag has been seen low.
- R9: After run rises, or after reset is released, all gates stay off until the synchronised run bit has been high for WAKE_CYC = CLK_KHZ*WAKE_US/1000 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 1 | Direction request (1 = forward) |
| enable_i | input | 1 | Drive enable, PWM chopped by the host |
| mode_i | input | 1 | Decay select when not enabled (1 = brake, 0 = fast decay) |
| awake_i | input | 1 | Run request (0 = sleep, bridge floated) |
| uv_flt_i | input | 1 | Supply undervoltage flag |
| ot_flt_i | input | 1 | Over-temperature flag |
| izero_i | input | 1 | Load current near zero |
| a_hi_o | output | 1 | Leg A high-side gate enable |
| a_lo_o | output | 1 | Leg A low-side gate enable |
| b_hi_o | output | 1 | Leg B high-side gate enable |
| b_lo_o | output | 1 | Leg B low-side gate enable |

## Verification
The bench checks that the zero-current latch survives the flag dropping and that it is released by a direction change and by enable. A design that failed to latch would re-drive a near-zero current into reversal, and a design that failed to release would leave the motor coasting after drive resumed. It counts the off gap of a leg during a reversal, because a missing or short crossover interval would let both switches of that leg conduct through the supply. It also probes the bridge partway through the wake hold-off and while the bridge is locked out at reset. Gates that came on early there would drive the bridge from an unsettled gate supply.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

   typedef enum logic [1:0] {
      LEG_FLOAT = 2'd0,
      LEG_HIGH  = 2'd1,
      LEG_LOW   = 2'd2
   } leg_cmd_t;

   // cycles in a nanosecond interval at a clock given in kHz
   function automatic int unsigned ns_to_cycles(int unsigned khz, int unsigned ns);
      longint unsigned prod;
      prod = longint'(khz) * longint'(ns);
      return int'(prod / 64'd1_000_000);
   endfunction

   // cycles in a microsecond interval at a clock given in kHz
   function automatic int unsigned us_to_cycles(int unsigned khz, int unsigned us);
      longint unsigned prod;
      prod = longint'(khz) * longint'(us);
      return int'(prod / 64'd1_000);
   endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
   parameter int unsigned     WIDTH   = 7,
   parameter int unsigned     STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hbg_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hbg_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) stg[s] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/hbg_ctrl.sv
module hbg_ctrl
   import hbg_pkg::*;
#(
   parameter int unsigned WAKE_CYC = 10_000
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     dir_req,
   input  logic     drive_en,
   input  logic     brake_sel,
   input  logic     run,
   input  logic     fault,
   input  logic     izero,
   output leg_cmd_t cmd_a,
   output leg_cmd_t cmd_b
);

   localparam int unsigned WW = $clog2(WAKE_CYC + 1);

   if (WAKE_CYC < 8) begin : g_bad_wake
      $error("hbg_ctrl: WAKE_CYC must be at least 8");
   end

   logic          fast;
   logic          dir;
   logic          dir_q;
   logic          zlat;
   logic [WW-1:0] wake_cnt;
   logic          ready;
   logic          hold;

   assign fast  = !drive_en && !brake_sel;
   assign dir   = drive_en ? dir_req : !dir_req;
   assign ready = (wake_cnt == WW'(WAKE_CYC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= 1'b0;
         zlat  <= 1'b0;
      end else begin
         dir_q <= dir;
         if (!fast || (dir != dir_q)) zlat <= 1'b0;
         else if (izero)              zlat <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wake_cnt <= '0;
      else if (!run)   wake_cnt <= '0;
      else if (!ready) wake_cnt <= wake_cnt + 1'b1;
   end

   assign hold = !run || fault || !ready || (fast && zlat);

   always_comb begin
      if (hold) begin
         cmd_a = LEG_FLOAT;
         cmd_b = LEG_FLOAT;
      end else if (!drive_en && brake_sel) begin
         cmd_a = LEG_LOW;
         cmd_b = LEG_LOW;
      end else begin
         cmd_a = dir ? LEG_HIGH : LEG_LOW;
         cmd_b = dir ? LEG_LOW  : LEG_HIGH;
      end
   end

endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
   import hbg_pkg::*;
#(
   parameter int unsigned DT_CYC = 25
) (
   input  logic     clk,
   input  logic     rst_n,
   input  leg_cmd_t cmd,
   output logic     gate_hi,
   output logic     gate_lo
);

   localparam int unsigned CW = $clog2(DT_CYC + 1);

   if (DT_CYC < 1) begin : g_bad_dt
      $error("hbg_leg: DT_CYC must be at least 1");
   end

   logic [CW-1:0] gap;
   logic          keep;

   assign keep = (cmd == LEG_HIGH && gate_hi) || (cmd == LEG_LOW && gate_lo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_hi <= 1'b0;
         gate_lo <= 1'b0;
         gap     <= '0;
      end else if (keep) begin
         gap <= '0;
      end else if (gate_hi || gate_lo) begin
         gate_hi <= 1'b0;
         gate_lo <= 1'b0;
         gap     <= '0;
      end else if (gap == CW'(DT_CYC)) begin
         gate_hi <= (cmd == LEG_HIGH);
         gate_lo <= (cmd == LEG_LOW);
      end else begin
         gap <= gap + 1'b1;
      end
   end

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
   import hbg_pkg::*;
#(
   parameter int unsigned CLK_KHZ     = 50_000,
   parameter int unsigned DEAD_NS     = 500,
   parameter int unsigned WAKE_US     = 200,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic phase_i,
   input  logic enable_i,
   input  logic mode_i,
   input  logic awake_i,
   input  logic uv_flt_i,
   input  logic ot_flt_i,
   input  logic izero_i,
   output logic a_hi_o,
   output logic a_lo_o,
   output logic b_hi_o,
   output logic b_lo_o
);

   localparam int unsigned DT_CYC   = ns_to_cycles(CLK_KHZ, DEAD_NS);
   localparam int unsigned WAKE_CYC = us_to_cycles(CLK_KHZ, WAKE_US);
   localparam int unsigned NIN      = 7;
   // bit order: izero, ot, uv, awake, mode, enable, phase
   localparam logic [NIN-1:0] SYNC_RST = 7'b0110000;

   if (DT_CYC < 1) begin : g_bad_dead
      $error("hbridge_gate_seq: dead time rounds to zero cycles");
   end

   logic [NIN-1:0] raw;
   logic [NIN-1:0] syn;
   leg_cmd_t       cmd [2];
   logic [1:0]     hi;
   logic [1:0]     lo;

   assign raw = {izero_i, ot_flt_i, uv_flt_i, awake_i, mode_i, enable_i, phase_i};

   hbg_sync #(
      .WIDTH   (NIN),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (syn)
   );

   hbg_ctrl #(
      .WAKE_CYC (WAKE_CYC)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .dir_req   (syn[0]),
      .drive_en  (syn[1]),
      .brake_sel (syn[2]),
      .run       (syn[3]),
      .fault     (syn[4] | syn[5]),
      .izero     (syn[6]),
      .cmd_a     (cmd[0]),
      .cmd_b     (cmd[1])
   );

   for (genvar g = 0; g < 2; g++) begin : g_leg
      hbg_leg #(
         .DT_CYC (DT_CYC)
      ) u_leg (
         .clk     (clk),
         .rst_n   (rst_n),
         .cmd     (cmd[g]),
         .gate_hi (hi[g]),
         .gate_lo (lo[g])
      );
   end

   assign a_hi_o = hi[0];
   assign a_lo_o = lo[0];
   assign b_hi_o = hi[1];
   assign b_lo_o = lo[1];

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker
   import hbg_pkg::*;
#(
   parameter int unsigned CLK_KHZ     = 50_000,
   parameter int unsigned DEAD_NS     = 500,
   parameter int unsigned WAKE_US     = 200,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic awake_i,
   input logic uv_flt_i,
   input logic ot_flt_i,
   input logic a_hi_o,
   input logic a_lo_o,
   input logic b_hi_o,
   input logic b_lo_o
);

   localparam int unsigned DT_CYC   = ns_to_cycles(CLK_KHZ, DEAD_NS);
   localparam int unsigned WAKE_CYC = us_to_cycles(CLK_KHZ, WAKE_US);
   localparam int unsigned LAT      = SYNC_STAGES + 1;

   logic [31:0] flt_run, slp_run, wk_run, gap_a, gap_b;
   logic        all_off, a_off, b_off;

   assign a_off   = !a_hi_o && !a_lo_o;
   assign b_off   = !b_hi_o && !b_lo_o;
   assign all_off = a_off && b_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_run <= '0;
         slp_run <= '0;
         wk_run  <= '0;
         gap_a   <= '0;
         gap_b   <= '0;
      end else begin
         flt_run <= (uv_flt_i || ot_flt_i) ? ((flt_run < LAT) ? flt_run + 1 : flt_run) : '0;
         slp_run <= !awake_i ? ((slp_run < LAT) ? slp_run + 1 : slp_run) : '0;
         wk_run  <= awake_i ? ((wk_run < WAKE_CYC) ? wk_run + 1 : wk_run) : '0;
         gap_a   <= a_off ? ((gap_a < DT_CYC + 4) ? gap_a + 1 : gap_a) : '0;
         gap_b   <= b_off ? ((gap_b < DT_CYC + 4) ? gap_b + 1 : gap_b) : '0;
      end
   end

   // R6
   a_r6_leg_a_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_hi_o && a_lo_o));
   a_r6_leg_b_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(b_hi_o && b_lo_o));
   // R7
   a_r7_dead_a: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(a_hi_o || a_lo_o) |-> gap_a >= DT_CYC);
   a_r7_dead_b: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(b_hi_o || b_lo_o) |-> gap_b >= DT_CYC);
   // R8
   a_r8_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
      flt_run >= LAT |-> all_off);
   // R5
   a_r5_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
      slp_run >= LAT |-> all_off);
   // R9
   a_r9_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wk_run >= LAT + 2 && wk_run < WAKE_CYC) |-> all_off);

endmodule

bind hbridge_gate_seq hbg_checker #(
   .CLK_KHZ     (CLK_KHZ),
   .DEAD_NS     (DEAD_NS),
   .WAKE_US     (WAKE_US),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .awake_i  (awake_i),
   .uv_flt_i (uv_flt_i),
   .ot_flt_i (ot_flt_i),
   .a_hi_o   (a_hi_o),
   .a_lo_o   (a_lo_o),
   .b_hi_o   (b_hi_o),
   .b_lo_o   (b_lo_o)
);

// File: tb/tb_hbridge_gate_seq.sv
`timescale 1ns/1ps
module tb_hbridge_gate_seq;

   localparam int CLK_PERIOD = 100;           // 10 MHz
   localparam int DT         = 5;             // 10_000 kHz * 500 ns
   localparam int WAKE       = 2000;          // 10_000 kHz * 200 us

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic phase_i = 1'b1, enable_i = 1'b1, mode_i = 1'b0, awake_i = 1'b1;
   logic uv_flt_i = 1'b1, ot_flt_i = 1'b0, izero_i = 1'b0;
   logic a_hi_o, a_lo_o, b_hi_o, b_lo_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hbridge_gate_seq #(
      .CLK_KHZ(10_000), .DEAD_NS(500), .WAKE_US(200), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .enable_i(enable_i),
      .mode_i(mode_i), .awake_i(awake_i), .uv_flt_i(uv_flt_i),
      .ot_flt_i(ot_flt_i), .izero_i(izero_i),
      .a_hi_o(a_hi_o), .a_lo_o(a_lo_o), .b_hi_o(b_hi_o), .b_lo_o(b_lo_o)
   );

   // {phase, enable, mode, izero, a_hi, a_lo, b_hi, b_lo}
   localparam logic [7:0] VEC [10] = '{
      8'b1100_1001, 8'b1110_1001, 8'b0100_0110, 8'b0110_0110,
      8'b1010_0101, 8'b0010_0101, 8'b1011_0101,
      8'b1000_0110, 8'b0000_1001, 8'b1101_1001
   };

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_gates(string req, logic [3:0] exp);
      logic [3:0] act;
      act = {a_hi_o, a_lo_o, b_hi_o, b_lo_o};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: gates=%b expected %b", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      errors++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      finish_run();
   end

   initial begin
      int gap;
      int overlap;
      // reset state
      wait_cyc(3);
      check_gates("R8 reset", 4'b0000);
      rst_n = 1'b1;
      // undervoltage still high: held off past the wake interval
      wait_cyc(WAKE + 100);
      check_gates("R8 held until uv clears", 4'b0000);
      uv_flt_i = 1'b0;
      wait_cyc(20);
      check_gates("R8 release forward", 4'b1001);

      // table walk
      for (int i = 0; i < 10; i++) begin
         {phase_i, enable_i, mode_i, izero_i} = VEC[i][7:4];
         wait_cyc(20);
         if (VEC[i][6])      check_gates("R1 drive", VEC[i][3:0]);
         else if (VEC[i][5]) check_gates("R2 brake", VEC[i][3:0]);
         else                check_gates("R3 fast decay", VEC[i][3:0]);
      end

      // R4 zero-current latch
      {phase_i, enable_i, mode_i, izero_i} = 4'b1000;
      wait_cyc(20);
      check_gates("R4 fast before zero", 4'b0110);
      izero_i = 1'b1;
      wait_cyc(10);
      check_gates("R4 float at zero", 4'b0000);
      izero_i = 1'b0;
      wait_cyc(10);
      check_gates("R4 latch holds", 4'b0000);
      phase_i = 1'b0;
      wait_cyc(20);
      check_gates("R4 dir change clears", 4'b1001);
      izero_i = 1'b1;
      wait_cyc(10);
      check_gates("R4 float again", 4'b0000);
      enable_i = 1'b1;
      wait_cyc(20);
      check_gates("R4 enable drives", 4'b0110);
      izero_i = 1'b0;
      enable_i = 1'b0;
      wait_cyc(20);
      check_gates("R4 enable cleared latch", 4'b1001);

      // R7 crossover gap on leg A reversal (high -> low), R6 overlap scan
      enable_i = 1'b1;
      phase_i  = 1'b0;
      gap = 0;
      overlap = 0;
      for (int c = 0; c < 30; c++) begin
         @(negedge clk);
         if (!a_hi_o && !a_lo_o) gap++;
         if ((a_hi_o && a_lo_o) || (b_hi_o && b_lo_o)) overlap++;
      end
      checks++;
      if (gap != DT + 1) begin
         errors++;
         $display("FAIL R7 off gap: %0d expected %0d", gap, DT + 1);
      end
      checks++;
      if (overlap != 0) begin
         errors++;
         $display("FAIL R6 overlap cycles: %0d expected 0", overlap);
      end
      check_gates("R7 after reversal", 4'b0110);

      // R5 sleep and R9 wake hold-off
      phase_i = 1'b1;
      wait_cyc(20);
      awake_i = 1'b0;
      wait_cyc(3);
      check_gates("R5 sleep floats", 4'b0000);
      mode_i = 1'b1;
      enable_i = 1'b0;
      wait_cyc(10);
      check_gates("R5 brake ignored in sleep", 4'b0000);
      mode_i = 1'b0;
      enable_i = 1'b1;
      awake_i = 1'b1;
      wait_cyc(WAKE - 100);
      check_gates("R9 hold-off", 4'b0000);
      wait_cyc(120);
      check_gates("R9 after hold-off", 4'b1001);

      // R8 over-temperature and undervoltage during drive
      ot_flt_i = 1'b1;
      wait_cyc(3);
      check_gates("R8 ot off", 4'b0000);
      ot_flt_i = 1'b0;
      wait_cyc(20);
      check_gates("R8 ot recover", 4'b1001);
      uv_flt_i = 1'b1;
      wait_cyc(10);
      check_gates("R8 uv off", 4'b0000);
      uv_flt_i = 1'b0;
      wait_cyc(20);
      check_gates("R8 uv recover", 4'b1001);

      // reset mid-run
      rst_n = 1'b0;
      wait_cyc(1);
      check_gates("R8 reset mid-run", 4'b0000);
      rst_n = 1'b1;
      wait_cyc(100);
      check_gates("R9 hold after reset", 4'b0000);

      finish_run();
   end

endmodule